// File: doc/BRIEF.md
# Seven-Output Phase-Locked PWM Timer

This block holds three up-counters that can be tied together and seven pulse-width outputs driven from them. Channel 0 is the master: its period register decides where every tied counter restarts, so all tied channels run the same count sequence. Outputs 0 to 2 compare against the channel 0 counter, outputs 3 and 4 against the channel 1 counter, and outputs 5 and 6 against the channel 2 counter. Each output has its own duty register, so the seven edges can be placed freely inside one common period.

Software uses a simple register port for writes and a combinational read port. A per-channel sync mask picks the tied channels. A write to the counter of a tied channel loads the same value into every tied counter in the same cycle. A common count enable (`cnt_en`) moves all counters forward together. The block has no data stream, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure.

Top module: `pwm7_sync`

## Requirements
- R1: Registers are written when `wr_en` is high at a clock edge and read back through `rd_data` in the same cycle as `rd_addr`. The map is: 0 sync mask (bits 2:0, bit k ties channel k), 1 output polarity (bits 6:0), 2/3/4 counters of channels 0/1/2, 5 period, 6 to 12 duty of outputs 0 to 6.
- R2: A write to the counter of a channel whose sync bit is set loads the written value into every counter whose sync bit is set, at the same edge. A counter write takes priority over counting.
- R3: A channel whose sync bit is clear is loaded only by a write to its own counter address. A write to a tied counter leaves it unchanged.
- R4: On an edge with `cnt_en` high, the channel 0 counter returns to 0 when it equals the period value, and otherwise adds 1. Every tied channel returns to 0 at that same edge, so the period lasts period+1 enabled cycles.
- R5: An untied channel 1 or 2 ignores the period match. It keeps adding 1 and wraps only at its full width.
- R6: With polarity bit 0, an output is high while its channel counter is below its duty value and low from the match until the counter returns to 0. The output changes at the same edge as the counter.
- R7: A duty value of 0 holds the output at the opposite level (low with polarity 0).
- R8: A nonzero duty value at or above the period holds the output at the initial level (high with polarity 0).
- R9: A polarity bit of 1 inverts its output in every case above.
- R10: With `cnt_en` low and no counter write, all counters hold their value.
- R11: After reset, all registers and counters are 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Common count enable for all three counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CW | Read data, combinational from `rd_addr` |
| pwm_out | output | 7 | PWM outputs 0 to 6 |

## Verification
A register or counter write shows up at the port after one edge, and reads are combinational. The bench therefore drives on the falling edge and checks at the next falling edge. Counters and outputs move together at each enabled edge. After a counter load, the bench compares, at every falling edge, the counter read-back and all seven outputs against a model that counts enabled edges modulo period+1. A duty or polarity write reaches the outputs one edge later than the register itself, so every such write is done before the counters are loaded and enabled.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;
  localparam int NCH  = 3;
  localparam int NOUT = 7;
  localparam int AW   = 4;

  localparam logic [AW-1:0] A_SYNC  = 4'd0;
  localparam logic [AW-1:0] A_POL   = 4'd1;
  localparam logic [AW-1:0] A_CNT0  = 4'd2;
  localparam logic [AW-1:0] A_PER   = 4'd5;
  localparam logic [AW-1:0] A_DUTY0 = 4'd6;

  // Which channel counter an output compares against: 3 / 2 / 2 split.
  function automatic int ch_of(input int o);
    return (o < 3) ? 0 : ((o < 5) ? 1 : 2);
  endfunction
endpackage

// File: rtl/pwm7_regs.sv
module pwm7_regs
  import pwm7_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [CW-1:0]              wr_data,
  output logic [NCH-1:0]             sync_q,
  output logic [NOUT-1:0]            pol_q,
  output logic [CW-1:0]              per_q,
  output logic [NOUT-1:0][CW-1:0]    duty_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pol_q  <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SYNC) sync_q <= wr_data[NCH-1:0];
      if (wr_addr == A_POL)  pol_q  <= wr_data[NOUT-1:0];
      if (wr_addr == A_PER)  per_q  <= wr_data;
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_duty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        duty_q[g] <= '0;
      else if (wr_en && wr_addr == A_DUTY0 + AW'(g))
        duty_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/pwm7_counter.sv
module pwm7_counter #(
  parameter int CW        = 16,
  parameter bit IS_MASTER = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          sync_bit,
  input  logic          shared_clr,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  logic clr;

  // Master restarts on its own period match; others follow only when tied.
  assign clr = IS_MASTER ? (cnt_q == per) : (sync_bit && shared_clr);

  always_comb begin
    if (ld)          cnt_nxt = ld_val;
    else if (cnt_en) cnt_nxt = clr ? '0 : cnt_q + 1'b1;
    else             cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm7_outgen.sv
module pwm7_outgen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] per,
  input  logic          pol,
  output logic          pwm
);
  logic active;

  // Zero duty never enters the initial phase; duty at/over period never leaves it.
  assign active = (duty != '0) && ((duty >= per) || (cnt_nxt < duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= active ^ pol;
  end
endmodule

// File: rtl/pwm7_sync.sv
module pwm7_sync
  import pwm7_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic [6:0]    pwm_out
);
  logic [NCH-1:0]          sync_q;
  logic [NOUT-1:0]         pol_q;
  logic [CW-1:0]           per_q;
  logic [NOUT-1:0][CW-1:0] duty_q;
  logic [NCH-1:0][CW-1:0]  cnt_q;
  logic [NCH-1:0][CW-1:0]  cnt_nxt;
  logic [NCH-1:0]          own_wr;
  logic [NCH-1:0]          ld;
  logic                    tied_wr;
  logic                    shared_clr;

  pwm7_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_q(sync_q), .pol_q(pol_q), .per_q(per_q),
    .duty_q(duty_q)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_own
    assign own_wr[k] = wr_en && (wr_addr == A_CNT0 + AW'(k));
  end

  assign tied_wr    = |(own_wr & sync_q);
  assign ld         = own_wr | (sync_q & {NCH{tied_wr}});
  assign shared_clr = (cnt_q[0] == per_q);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm7_counter #(.CW(CW), .IS_MASTER(k == 0)) u_cnt (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ld(ld[k]),
      .ld_val(wr_data), .sync_bit(sync_q[k]), .shared_clr(shared_clr),
      .per(per_q), .cnt_q(cnt_q[k]), .cnt_nxt(cnt_nxt[k])
    );
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    localparam int CH = ch_of(o);
    pwm7_outgen #(.CW(CW)) u_out (
      .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt[CH]), .duty(duty_q[o]),
      .per(per_q), .pol(pol_q[o]), .pwm(pwm_out[o])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_SYNC) rd_data = CW'(sync_q);
    if (rd_addr == A_POL)  rd_data = CW'(pol_q);
    if (rd_addr == A_PER)  rd_data = per_q;
    for (int k = 0; k < NCH; k++)
      if (rd_addr == A_CNT0 + AW'(k)) rd_data = cnt_q[k];
    for (int o = 0; o < NOUT; o++)
      if (rd_addr == A_DUTY0 + AW'(o)) rd_data = duty_q[o];
  end
endmodule

// File: rtl/pwm7_sync_chk.sv
module pwm7_sync_chk
  import pwm7_pkg::*;
#(
  parameter int CW = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cnt_en,
  input logic                    wr_en,
  input logic [AW-1:0]           wr_addr,
  input logic [6:0]              pwm_out,
  input logic [NCH-1:0]          sync_q,
  input logic [NOUT-1:0]         pol_q,
  input logic [CW-1:0]           per_q,
  input logic [NOUT-1:0][CW-1:0] duty_q,
  input logic [NCH-1:0][CW-1:0]  cnt_q
);
  a_r2_tied_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT0 && sync_q[0] && sync_q[1])
      |=> (cnt_q[1] == cnt_q[0]));

  a_r4_shared_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_en && sync_q[2] && cnt_q[0] == per_q)
      |=> (cnt_q[0] == '0 && cnt_q[2] == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> $stable(cnt_q));

  for (genvar o = 0; o < NOUT; o++) begin : g_o
    a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q[o] == '0) |=> (pwm_out[o] == $past(pol_q[o])));

    a_r8_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q[o] != '0 && duty_q[o] >= per_q) |=> (pwm_out[o] != $past(pol_q[o])));
  end
endmodule

bind pwm7_sync pwm7_sync_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .wr_addr(wr_addr), .pwm_out(pwm_out), .sync_q(sync_q), .pol_q(pol_q),
  .per_q(per_q), .duty_q(duty_q), .cnt_q(cnt_q)
);

// File: tb/pwm7_sync_bench.sv
module pwm7_sync_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [6:0]    pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm7_sync #(.CW(CW)) u_pwm7_sync (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [CW-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic lvl(input int c, input int d, input int p, input logic pol);
    return ((d != 0) && ((d >= p) || (c < d))) ^ pol;
  endfunction

  task automatic t_reset();
    logic [CW-1:0] v;
    chk("R11 outputs", pwm_out, 7'h00);
    for (int a = 0; a < 13; a++) begin
      rd(4'(a), v);
      chk("R11 register", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [CW-1:0] v;
    wr(4'd5, 16'h1234);
    wr(4'd12, 16'h00ab);
    wr(4'd1, 16'hffff);
    rd(4'd5, v);  chk("R1 period", v, 16'h1234);
    rd(4'd12, v); chk("R1 duty6", v, 16'h00ab);
    rd(4'd1, v);  chk("R1 polarity width", v, 16'h007f);
    wr(4'd1, 16'h0000);
  endtask

  task automatic t_sync_write();
    logic [CW-1:0] v;
    wr(4'd5, 16'd100);
    wr(4'd0, 16'h0007);
    wr(4'd3, 16'd5);
    for (int k = 0; k < 3; k++) begin
      rd(4'(2 + k), v); chk("R2 tied load", v, 5);
    end
    wr(4'd0, 16'h0005);
    wr(4'd2, 16'd40);
    rd(4'd2, v); chk("R2 tied ch0", v, 40);
    rd(4'd4, v); chk("R2 tied ch2", v, 40);
    rd(4'd3, v); chk("R3 untied ch1 kept", v, 5);
    wr(4'd3, 16'd9);
    rd(4'd3, v); chk("R3 own write ch1", v, 9);
    rd(4'd2, v); chk("R3 own write no spread", v, 40);
  endtask

  task automatic t_hold();
    logic [CW-1:0] v;
    cnt_en = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd2, v); chk("R10 hold ch0", v, 40);
    rd(4'd3, v); chk("R10 hold ch1", v, 9);
  endtask

  task automatic t_pwm(input logic [6:0] pol, input int cycles, input string tag);
    int p = 9;
    int duty[7] = '{3, 5, 1, 9, 0, 7, 12};
    logic [CW-1:0] v;
    wr(4'd5, 16'(p));
    wr(4'd1, 16'(pol));
    for (int o = 0; o < 7; o++) wr(4'(6 + o), 16'(duty[o]));
    wr(4'd0, 16'h0007);
    wr(4'd2, 16'd0);
    cnt_en = 1'b1;
    for (int t = 0; t < cycles; t++) begin
      int c = t % (p + 1);
      logic [6:0] e;
      for (int o = 0; o < 7; o++) e[o] = lvl(c, duty[o], p, pol[o]);
      rd(4'd3, v); chk("R4 tied ch1 count", v, c);
      rd(4'd2, v); chk("R4 master count", v, c);
      chk({tag, " outputs"}, pwm_out, e);
      @(negedge clk);
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_independent();
    logic [CW-1:0] v;
    wr(4'd0, 16'h0001);
    wr(4'd5, 16'd9);
    wr(4'd2, 16'd0);
    wr(4'd3, 16'd5);
    wr(4'd4, 16'hfffe);
    cnt_en = 1'b1;
    repeat (12) @(negedge clk);
    cnt_en = 1'b0;
    rd(4'd2, v); chk("R5 master wraps at period", v, 2);
    rd(4'd3, v); chk("R5 untied ch1 passes period", v, 17);
    rd(4'd4, v); chk("R5 untied ch2 full-width wrap", v, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_regs();
    t_sync_write();
    t_hold();
    t_pwm(7'b0000000, 25, "R6 R7 R8");
    t_pwm(7'b1010101, 12, "R9 inverted");
    t_independent();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule